// File: doc/BRIEF.md
# Exclusive Two-Level Cache Tag Tracker

This block keeps the tag state of a pair of single-set caches arranged as an exclusive hierarchy. The upper level (near) holds up to `L1_WAYS` block addresses and replaces by least-recent use. The lower level (far) holds up to `L2_WAYS` block addresses. It is filled only by blocks pushed out of the near level and discards entries in the order they arrived. A block address is tracked in at most one level at any time. Both levels share one block size, so the block address is the whole tag.

Each valid-qualified block address is classified as a near hit, a far hit, or a miss in both levels. The tag state is updated in the same clock edge. The classification comes out registered, one cycle later. Three running counters accumulate the number of each outcome. One access per cycle is accepted with no stall. The block is meant to sit next to an address stream and measure hit behaviour for a chosen pair of associativities.

Top module: `excl_cache_pair`

## Requirements
- R1: After reset, both levels hold no valid entry, all three counters read zero and `result_vld_o` is low.
- R2: An access presented with `valid_i` high produces `result_vld_o` high on the next cycle, with `result_o` equal to 2'b00 for a near hit, 2'b01 for a far hit and 2'b10 for a miss in both. A cycle without `valid_i` gives `result_vld_o` low on the next cycle, and 2'b11 never appears with `result_vld_o` high.
- R3: A near hit leaves the far level unchanged and makes the block the most recently used in the near level.
- R4: When the near level is full and an access misses it, the least recently used near entry is the one displaced.
- R5: On a far hit, the block is removed from the far level and placed in the near level as most recently used. The displaced near entry, if any, is inserted into the far level.
- R6: On a miss in both levels, the block is placed only in the near level. The displaced near entry goes to the far level, and when the far level is full its oldest entry is dropped.
- R7: Far-level age is insertion order only. Removal of an entry by a far hit does not change the relative age of the others.
- R8: No block address is valid in both levels at once.
- R9: The near-hit, far-hit and miss counters each increase by one in the cycle that a result of their class is reported, and hold otherwise.
- R10: Accesses on consecutive cycles are each classified against the state left by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Access present this cycle |
| addr_i | input | ADDR_W | Block address of the access |
| result_vld_o | output | 1 | Classification valid |
| result_o | output | 2 | 00 near hit, 01 far hit, 10 miss in both |
| l1_hits_o | output | CNT_W | Near-hit count |
| l2_hits_o | output | CNT_W | Far-hit count |
| misses_o | output | CNT_W | Miss count |

## Verification
The bench targets the points where an exclusive pair most often goes wrong. A far hit that leaves its copy behind would later show up as a second far hit for the same block. A far hit that refreshes age, or that compacts the far queue wrongly, drops the wrong entry when the far level overflows. A near victim taken as most instead of least recently used turns later near hits into far hits. A short trace with hand-worked outcomes, a far-overflow sequence and a long back-to-back pseudo-random stream are compared access by access against a bench model. The bench also checks that near hits do not disturb the far ordering and that the counters agree with the outcomes seen.

// File: rtl/excl_pkg.sv
package excl_pkg;
  typedef enum logic [1:0] {
    RES_L1_HIT = 2'b00,
    RES_L2_HIT = 2'b01,
    RES_MISS   = 2'b10
  } res_e;
endpackage

// File: rtl/excl_l1_lru.sv
// Near level: index 0 is most recently used, valid entries form a prefix.
module excl_l1_lru #(
  parameter int WAYS   = 2,
  parameter int ADDR_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          upd_i,
  input  logic [ADDR_W-1:0]             addr_i,
  output logic                          hit_o,
  output logic                          victim_vld_o,
  output logic [ADDR_W-1:0]             victim_tag_o,
  output logic [WAYS-1:0][ADDR_W-1:0]   tag_o,
  output logic [WAYS-1:0]               vld_o
);
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0][ADDR_W-1:0] tag_q, tag_d;
  logic [WAYS-1:0]             vld_q, vld_d;
  logic [WAYS-1:0]             match;
  logic [IDX_W-1:0]            hit_idx, pos;

  always_comb begin
    hit_idx = '0;
    for (int k = 0; k < WAYS; k++) begin
      match[k] = vld_q[k] && (tag_q[k] == addr_i);
      if (match[k]) hit_idx = IDX_W'(k);
    end
  end

  assign hit_o        = |match;
  assign pos          = hit_o ? hit_idx : IDX_W'(WAYS - 1);
  assign victim_vld_o = !hit_o && vld_q[WAYS-1];
  assign victim_tag_o = tag_q[WAYS-1];

  for (genvar k = 0; k < WAYS; k++) begin : g_shift
    if (k == 0) begin : g_head
      assign tag_d[k] = addr_i;
      assign vld_d[k] = 1'b1;
    end else begin : g_body
      assign tag_d[k] = (k <= int'(pos)) ? tag_q[k-1] : tag_q[k];
      assign vld_d[k] = (k <= int'(pos)) ? vld_q[k-1] : vld_q[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
      vld_q <= '0;
    end else if (upd_i) begin
      tag_q <= tag_d;
      vld_q <= vld_d;
    end
  end

  assign tag_o = tag_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/excl_l2_fifo.sv
// Far level: index 0 is newest, last index oldest, valid entries form a prefix.
module excl_l2_fifo #(
  parameter int WAYS   = 2,
  parameter int ADDR_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          upd_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          ins_i,
  input  logic [ADDR_W-1:0]             ins_tag_i,
  output logic                          hit_o,
  output logic [WAYS-1:0][ADDR_W-1:0]   tag_o,
  output logic [WAYS-1:0]               vld_o
);
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0][ADDR_W-1:0] tag_q, tag_d, prv_tag, nxt_tag;
  logic [WAYS-1:0]             vld_q, vld_d, prv_vld, nxt_vld;
  logic [WAYS-1:0]             match;
  logic [IDX_W-1:0]            hit_idx;

  always_comb begin
    hit_idx = '0;
    for (int k = 0; k < WAYS; k++) begin
      match[k] = vld_q[k] && (tag_q[k] == addr_i);
      if (match[k]) hit_idx = IDX_W'(k);
    end
  end
  assign hit_o = |match;

  // neighbour views: entry one newer (or the inserted tag) and one older
  for (genvar k = 0; k < WAYS; k++) begin : g_nb
    if (k == 0) begin : g_p0
      assign prv_tag[k] = ins_tag_i;
      assign prv_vld[k] = 1'b1;
    end else begin : g_pk
      assign prv_tag[k] = tag_q[k-1];
      assign prv_vld[k] = vld_q[k-1];
    end
    if (k == WAYS - 1) begin : g_nl
      assign nxt_tag[k] = '0;
      assign nxt_vld[k] = 1'b0;
    end else begin : g_nk
      assign nxt_tag[k] = tag_q[k+1];
      assign nxt_vld[k] = vld_q[k+1];
    end
  end

  always_comb begin
    for (int k = 0; k < WAYS; k++) begin
      tag_d[k] = tag_q[k];
      vld_d[k] = vld_q[k];
      if (hit_o && ins_i) begin
        if (k <= int'(hit_idx)) begin
          tag_d[k] = prv_tag[k];
          vld_d[k] = prv_vld[k];
        end
      end else if (hit_o) begin
        if (k >= int'(hit_idx)) begin
          tag_d[k] = nxt_tag[k];
          vld_d[k] = nxt_vld[k];
        end
      end else if (ins_i) begin
        tag_d[k] = prv_tag[k];
        vld_d[k] = prv_vld[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
      vld_q <= '0;
    end else if (upd_i) begin
      tag_q <= tag_d;
      vld_q <= vld_d;
    end
  end

  assign tag_o = tag_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/excl_cache_pair.sv
module excl_cache_pair #(
  parameter int ADDR_W  = 16,
  parameter int L1_WAYS = 2,
  parameter int L2_WAYS = 2,
  parameter int CNT_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              result_vld_o,
  output logic [1:0]        result_o,
  output logic [CNT_W-1:0]  l1_hits_o,
  output logic [CNT_W-1:0]  l2_hits_o,
  output logic [CNT_W-1:0]  misses_o
);
  import excl_pkg::*;

  logic                             l1_hit, l2_hit, vic_vld;
  logic [ADDR_W-1:0]                vic_tag;
  logic [L1_WAYS-1:0][ADDR_W-1:0]   l1_tag;
  logic [L1_WAYS-1:0]               l1_vld;
  logic [L2_WAYS-1:0][ADDR_W-1:0]   l2_tag;
  logic [L2_WAYS-1:0]               l2_vld;
  res_e                             res_d;

  excl_l1_lru #(.WAYS(L1_WAYS), .ADDR_W(ADDR_W)) u_l1 (
    .clk_i, .rst_ni,
    .upd_i        (valid_i),
    .addr_i,
    .hit_o        (l1_hit),
    .victim_vld_o (vic_vld),
    .victim_tag_o (vic_tag),
    .tag_o        (l1_tag),
    .vld_o        (l1_vld)
  );

  excl_l2_fifo #(.WAYS(L2_WAYS), .ADDR_W(ADDR_W)) u_l2 (
    .clk_i, .rst_ni,
    .upd_i     (valid_i && !l1_hit),
    .addr_i,
    .ins_i     (vic_vld),
    .ins_tag_i (vic_tag),
    .hit_o     (l2_hit),
    .tag_o     (l2_tag),
    .vld_o     (l2_vld)
  );

  assign res_d = l1_hit ? RES_L1_HIT : (l2_hit ? RES_L2_HIT : RES_MISS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_vld_o <= 1'b0;
      result_o     <= 2'b00;
      l1_hits_o    <= '0;
      l2_hits_o    <= '0;
      misses_o     <= '0;
    end else begin
      result_vld_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        unique case (res_d)
          RES_L1_HIT: l1_hits_o <= l1_hits_o + 1'b1;
          RES_L2_HIT: l2_hits_o <= l2_hits_o + 1'b1;
          default:    misses_o  <= misses_o + 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/excl_cache_pair_sva.sv
module excl_cache_pair_sva #(
  parameter int ADDR_W  = 16,
  parameter int L1_WAYS = 2,
  parameter int L2_WAYS = 2,
  parameter int CNT_W   = 16
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           valid_i,
  input logic [ADDR_W-1:0]              addr_i,
  input logic                           result_vld_o,
  input logic [1:0]                     result_o,
  input logic [CNT_W-1:0]               l1_hits_o,
  input logic [CNT_W-1:0]               l2_hits_o,
  input logic [CNT_W-1:0]               misses_o,
  input logic [L1_WAYS-1:0][ADDR_W-1:0] l1_tag,
  input logic [L1_WAYS-1:0]             l1_vld,
  input logic [L2_WAYS-1:0][ADDR_W-1:0] l2_tag,
  input logic [L2_WAYS-1:0]             l2_vld
);
  logic overlap;
  always_comb begin
    overlap = 1'b0;
    for (int i = 0; i < L1_WAYS; i++)
      for (int j = 0; j < L2_WAYS; j++)
        if (l1_vld[i] && l2_vld[j] && l1_tag[i] == l2_tag[j]) overlap = 1'b1;
  end

  p_vld_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> result_vld_o);
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !result_vld_o);
  p_code_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_vld_o |-> result_o != 2'b11);
  p_l1hit_keeps_l2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_vld_o && result_o == 2'b00) |-> (l2_tag == $past(l2_tag) && l2_vld == $past(l2_vld)));
  p_miss_fills_l1_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_vld_o && result_o == 2'b10) |-> (l1_vld[0] && l1_tag[0] == $past(addr_i)));
  p_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !overlap);
  p_l1_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_vld_o && result_o == 2'b00) |-> l1_hits_o == $past(l1_hits_o) + 1'b1);
  p_l2_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_vld_o && result_o == 2'b01) |-> l2_hits_o == $past(l2_hits_o) + 1'b1);
  p_miss_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !result_vld_o |-> (misses_o == $past(misses_o) && l1_hits_o == $past(l1_hits_o)));
endmodule

bind excl_cache_pair excl_cache_pair_sva #(
  .ADDR_W(ADDR_W), .L1_WAYS(L1_WAYS), .L2_WAYS(L2_WAYS), .CNT_W(CNT_W)
) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .addr_i(addr_i),
  .result_vld_o(result_vld_o), .result_o(result_o),
  .l1_hits_o(l1_hits_o), .l2_hits_o(l2_hits_o), .misses_o(misses_o),
  .l1_tag(l1_tag), .l1_vld(l1_vld), .l2_tag(l2_tag), .l2_vld(l2_vld)
);

// File: tb/sim_excl_cache_pair.sv
`timescale 1ns/1ps
module sim_excl_cache_pair;
  localparam int AW = 16, W1 = 2, W2 = 2, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0, vld = 1'b0;
  logic [AW-1:0] addr = '0;
  logic res_vld;
  logic [1:0] res;
  logic [CW-1:0] c1, c2, cm;

  int n_run = 0, n_fail = 0;
  int e1 = 0, e2 = 0, em = 0;
  bit done = 0;

  // bench model: near index 0 = MRU, far index 0 = newest
  logic [AW-1:0] m1 [W1];
  bit            m1v[W1];
  logic [AW-1:0] m2 [W2];
  bit            m2v[W2];

  always #10 clk = ~clk;

  excl_cache_pair #(.ADDR_W(AW), .L1_WAYS(W1), .L2_WAYS(W2), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .addr_i(addr),
    .result_vld_o(res_vld), .result_o(res),
    .l1_hits_o(c1), .l2_hits_o(c2), .misses_o(cm)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(input logic [AW-1:0] a);
    int hit1 = -1, hit2 = -1, pos;
    bit vv; logic [AW-1:0] vt;
    for (int i = 0; i < W1; i++) if (m1v[i] && m1[i] == a) hit1 = i;
    if (hit1 >= 0) begin
      for (int i = hit1; i > 0; i--) m1[i] = m1[i-1];
      m1[0] = a;
      return 0;
    end
    for (int j = 0; j < W2; j++) if (m2v[j] && m2[j] == a) hit2 = j;
    vv = m1v[W1-1]; vt = m1[W1-1];
    for (int i = W1-1; i > 0; i--) begin m1[i] = m1[i-1]; m1v[i] = m1v[i-1]; end
    m1[0] = a; m1v[0] = 1;
    if (hit2 >= 0) begin
      for (int j = hit2; j < W2-1; j++) begin m2[j] = m2[j+1]; m2v[j] = m2v[j+1]; end
      m2v[W2-1] = 0;
    end
    if (vv) begin
      for (int j = W2-1; j > 0; j--) begin m2[j] = m2[j-1]; m2v[j] = m2v[j-1]; end
      m2[0] = vt; m2v[0] = 1;
    end
    pos = (hit2 >= 0) ? 1 : 2;
    return pos;
  endfunction

  task automatic do_reset();
    vld = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < W1; i++) m1v[i] = 0;
    for (int j = 0; j < W2; j++) m2v[j] = 0;
    e1 = 0; e2 = 0; em = 0;
    chk("R1 vld", int'(res_vld), 0);
    chk("R1 cnt", int'(c1) + int'(c2) + int'(cm), 0);
  endtask

  // one access; consecutive calls are back-to-back
  task automatic acc(input string req, input logic [AW-1:0] a, input int exp_hard = -1);
    int exp;
    vld = 1; addr = a;
    @(negedge clk);
    exp = model(a);
    if (exp == 0) e1++; else if (exp == 1) e2++; else em++;
    chk({req, " vld"}, int'(res_vld), 1);
    chk({req, " code"}, int'(res), exp);
    if (exp_hard >= 0) chk({req, " hand"}, int'(res), exp_hard);
    vld = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      chk("R2 idle", int'(res_vld), 0);
    end
  endtask

  task automatic chk_counts(input string req);
    chk({req, " near"}, int'(c1), e1);
    chk({req, " far"},  int'(c2), e2);
    chk({req, " miss"}, int'(cm), em);
  endtask

  task automatic t_basic();  // R1 R2 R3 R5 R6
    do_reset();
    acc("R6 b", 16'h00B, 2);
    acc("R6 a", 16'h00A, 2);
    acc("R3 b", 16'h00B, 0);
    acc("R3 a", 16'h00A, 0);
    acc("R6 c", 16'h00C, 2);
    idle(2);
    acc("R3 a2", 16'h00A, 0);
    acc("R5 b", 16'h00B, 1);
    acc("R5 c", 16'h00C, 1);
    chk_counts("R9 basic");
  endtask

  task automatic t_lru();  // R4
    do_reset();
    acc("R4 f1", 16'h1, 2);
    acc("R4 f2", 16'h2, 2);
    acc("R4 touch", 16'h1, 0);
    acc("R4 f3", 16'h3, 2);   // displaces 2, not 1
    acc("R4 keep", 16'h1, 0);
    acc("R4 gone", 16'h2, 1);
  endtask

  task automatic t_fifo();  // R6 R7 R8
    do_reset();
    for (int i = 1; i <= 5; i++) acc("R6 fill", AW'(i), 2);
    acc("R6 drop", 16'h1, 2);   // oldest far entry was discarded
    acc("R7 age", 16'h3, 1);
    acc("R7 near", 16'h3, 0);
    acc("R7 ord", 16'h5, 1);
    acc("R8 once", 16'h3, 0);
    acc("R8 move", 16'h9, 2);
    acc("R8 back", 16'h1, 1);
    chk_counts("R9 fifo");
  endtask

  task automatic t_stream();  // R10 R9 R8
    logic [15:0] lf = 16'hACE1;
    do_reset();
    for (int n = 0; n < 400; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      acc("R10 str", AW'(lf[2:0] % 6), -1);
      if (lf[7:4] == 4'h0) idle(1);
    end
    chk_counts("R9 stream");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_basic();
    t_lru();
    t_fifo();
    t_stream();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule